// File: doc/BRIEF.md
# Smart Card Reset Line Timer

This block drives the reset contact of a smart card in a reader front end. It has three ways to produce that line. In software mode the line copies one control bit. In pin-follow mode it copies an external reset input, so a rising edge on that input raises the line. In timed mode a loadable 16-bit down-counter holds the line low for a programmed number of card clock cycles after a cold activation, and then releases it on its own.

Once the line has been released in timed mode, a warm reset request pulls it low again for the same programmed count and then releases it again. After every release the counter counts up through the card clock cycles that have elapsed. On the first falling edge of the card I/O line that follows the release, that elapsed count is stored in a capture register. Software can then read how long the card took to start its answer.

Card clock cycles are presented as a one-cycle enable `cclk_en` in the system clock domain. The counter moves only on cycles where the enable is high, so a stopped card clock freezes the count. The target count is written as two byte registers, the low byte and the high byte. Their reset value gives a count of 400.

Top module: `card_rst_timer`

## Requirements
- R1: After reset, `crst` and `done` are 0 and `cap_val` is 0. If a timed cold activation is started without writing the target registers, `crst` rises on the 400th card clock tick.
- R2: Writes use `wr_sel` codes 0 = target low byte, 1 = target high byte and 2 = control. The control byte has these bits: bit0 software reset level, bit1 timed mode, bit2 pin-follow mode, bit3 cold start (write 1 to start) and bit4 warm reset (write 1 to request). With bits 1 and 2 clear, `crst` equals control bit0 from the cycle after the write.
- R3: With control bit2 set, `crst` equals `ext_rst` delayed by one clock: it rises one cycle after `ext_rst` rises and falls one cycle after it falls. This mode takes precedence over bits 0 and 1.
- R4: With timed mode already set, a control write with bit3 set starts a cold activation with `crst` low. For a target N of 1 or more, `crst` stays low through N-1 card clock ticks and is high after the Nth tick. The first tick that counts is the one in the second clock cycle after the write.
- R5: Cycles with `cclk_en` low do not advance the count, however many of them pass.
- R6: A target of 0 releases `crst` two clock cycles after the start write's cycle, with no tick needed. A target of 1 releases it on the first tick.
- R7: `done` is high for exactly one clock cycle, the cycle in which `crst` first reads high after a timed release.
- R8: Writing the low byte while a count is running restarts the count from the new 16-bit target. Writing the high byte while a count is running does not change the count that is running.
- R9: A control write with bit4 set, made while the line is released in timed mode, drives `crst` low from the second cycle after the write. `crst` then releases again after N ticks. The same request is ignored while idle or while a cold count is running.
- R10: After each timed release, the first falling edge of `card_io` stores in `cap_val` the number of ticks counted since that release. Falling edges before the release, and falling edges after the first one, leave `cap_val` unchanged.
- R11: Clearing control bit1 abandons timed operation. `crst` then follows bit0, and setting bit1 again without bit3 leaves `crst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 target low, 1 target high, 2 control |
| wr_data | input | 8 | Write data byte |
| cclk_en | input | 1 | One card clock cycle elapsed this cycle |
| ext_rst | input | 1 | External reset level used in pin-follow mode |
| card_io | input | 1 | Card I/O line level |
| crst | output | 1 | Card reset line |
| done | output | 1 | One-cycle pulse when a timed count releases the line |
| cap_val | output | 16 | Captured elapsed tick count |

## Verification
If the down-counter loses or gains a tick, the release lands on a different tick than the target, so the bench checks `crst` just before and just after the expected tick across a sweep of targets. A counter that did not restart on a low-byte write shows up as a release several ticks late. A capture that is not properly armed or disarmed puts a wrong value on `cap_val` in the cycle after a falling I/O edge. A sequencer that wrongly accepts a warm request shows up right away, because `crst` drops or releases late within the same short window.

// File: rtl/crt_pkg.sv
package crt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COLD = 2'd1,
        ST_WARM = 2'd2,
        ST_POST = 2'd3
    } seq_state_e;

    localparam logic [1:0] SEL_LSB  = 2'd0;
    localparam logic [1:0] SEL_MSB  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int B_SW   = 0;
    localparam int B_AUTO = 1;
    localparam int B_HW   = 2;
    localparam int B_GO   = 3;
    localparam int B_WARM = 4;
endpackage

// File: rtl/crt_regs.sv
module crt_regs import crt_pkg::*; #(
    parameter int DW = 8,
    parameter int TW = 2 * DW,
    parameter logic [TW-1:0] RST_VAL = TW'(400)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          ext_rst,
    output logic [TW-1:0] target,
    output logic          sw_bit,
    output logic          auto_en,
    output logic          hw_sel,
    output logic          go,
    output logic          warm,
    output logic          reload,
    output logic          ext_q
);
    typedef struct packed {
        logic [DW-1:0] lsb;
        logic [DW-1:0] msb;
        logic          sw;
        logic          auto_m;
        logic          hw;
        logic          go;
        logic          warm;
        logic          lsb_wr;
        logic          ext;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d        = q;
        d.go     = 1'b0;
        d.warm   = 1'b0;
        d.lsb_wr = 1'b0;
        d.ext    = ext_rst;
        if (wr_en) begin
            case (wr_sel)
                SEL_LSB: begin
                    d.lsb    = wr_data;
                    d.lsb_wr = 1'b1;
                end
                SEL_MSB: d.msb = wr_data;
                SEL_CTRL: begin
                    d.sw     = wr_data[B_SW];
                    d.auto_m = wr_data[B_AUTO];
                    d.hw     = wr_data[B_HW];
                    d.go     = wr_data[B_GO];
                    d.warm   = wr_data[B_WARM];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.lsb    <= RST_VAL[DW-1:0];
            q.msb    <= RST_VAL[TW-1:DW];
        end else begin
            q <= d;
        end
    end

    assign target  = {q.msb, q.lsb};
    assign sw_bit  = q.sw;
    assign auto_en = q.auto_m;
    assign hw_sel  = q.hw;
    assign go      = q.go;
    assign warm    = q.warm;
    assign reload  = q.lsb_wr;
    assign ext_q   = q.ext;
endmodule

// File: rtl/crt_seq.sv
module crt_seq import crt_pkg::*; #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_en,
    input  logic          go,
    input  logic          warm,
    input  logic          reload,
    input  logic [TW-1:0] target,
    input  logic          tick,
    output logic [TW-1:0] count,
    output logic          released,
    output logic          done
);
    localparam logic [TW-1:0] CNT_MAX = '1;
    localparam logic [TW-1:0] CNT_ONE = TW'(1);

    typedef struct packed {
        seq_state_e    state;
        logic [TW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!auto_en) begin
            d.state = ST_IDLE;
            d.cnt   = '0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    if (go) begin
                        d.state = ST_COLD;
                        d.cnt   = target;
                    end
                end
                ST_COLD, ST_WARM: begin
                    if (reload) begin
                        d.cnt = target;
                    end else if (q.cnt == '0 || (tick && q.cnt == CNT_ONE)) begin
                        d.state = ST_POST;
                        d.cnt   = '0;
                        d.done  = 1'b1;
                    end else if (tick) begin
                        d.cnt = q.cnt - CNT_ONE;
                    end
                end
                ST_POST: begin
                    if (warm) begin
                        d.state = ST_WARM;
                        d.cnt   = target;
                    end else if (tick && q.cnt != CNT_MAX) begin
                        d.cnt = q.cnt + CNT_ONE;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.cnt   <= '0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign count    = q.cnt;
    assign released = (q.state == ST_POST);
    assign done     = q.done;

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R7
    done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> q.state == ST_POST);

    // R10
    elapsed_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_POST && $past(q.state) == ST_POST) |-> q.cnt >= $past(q.cnt));

    // R5
    countdown_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_COLD || q.state == ST_WARM) && $past(q.state) == q.state
         && !$past(reload)) |-> q.cnt <= $past(q.cnt));
endmodule

// File: rtl/crt_capture.sv
module crt_capture #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          released,
    input  logic [TW-1:0] elapsed,
    input  logic          io,
    output logic [TW-1:0] cap
);
    typedef struct packed {
        logic          io;
        logic          armed;
        logic [TW-1:0] cap;
    } cap_t;

    cap_t q, d;
    logic fall;

    always_comb begin
        fall = q.io && !io;
        d    = q;
        d.io = io;
        if (arm) begin
            d.armed = 1'b1;
        end else if (!released) begin
            d.armed = 1'b0;
        end else if (q.armed && fall) begin
            d.cap   = elapsed;
            d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.io    <= 1'b1;
            q.armed <= 1'b0;
            q.cap   <= '0;
        end else begin
            q <= d;
        end
    end

    assign cap = q.cap;

    // R10
    cap_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.cap) |-> $past(q.armed) && $past(released));
endmodule

// File: rtl/card_rst_timer.sv
module card_rst_timer import crt_pkg::*; #(
    parameter int DW = 8,
    parameter int DEF_LOAD = 400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DW-1:0]       wr_data,
    input  logic                cclk_en,
    input  logic                ext_rst,
    input  logic                card_io,
    output logic                crst,
    output logic                done,
    output logic [2*DW-1:0]     cap_val
);
    localparam int TW = 2 * DW;
    localparam logic [TW-1:0] RST_VAL = TW'(DEF_LOAD);

    logic [TW-1:0] target;
    logic [TW-1:0] count;
    logic          sw_bit, auto_en, hw_sel, go, warm, reload, ext_q, released;

    crt_regs #(.DW(DW), .TW(TW), .RST_VAL(RST_VAL)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_rst(ext_rst), .target(target),
        .sw_bit(sw_bit), .auto_en(auto_en), .hw_sel(hw_sel), .go(go),
        .warm(warm), .reload(reload), .ext_q(ext_q)
    );

    crt_seq #(.TW(TW)) seq_i (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .go(go), .warm(warm),
        .reload(reload), .target(target), .tick(cclk_en), .count(count),
        .released(released), .done(done)
    );

    crt_capture #(.TW(TW)) cap_i (
        .clk(clk), .rst_n(rst_n), .arm(done), .released(released),
        .elapsed(count), .io(card_io), .cap(cap_val)
    );

    always_comb begin
        if (hw_sel)       crst = ext_q;
        else if (auto_en) crst = released;
        else              crst = sw_bit;
    end

    // R3
    hw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_sel && $past(hw_sel) && $rose(ext_q)) |-> crst);
endmodule

// File: tb/card_rst_timer_tb_top.sv
`timescale 1ns/1ps
module card_rst_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        cclk_en = 1'b0;
    logic        ext_rst = 1'b0;
    logic        card_io = 1'b1;
    logic        crst, done;
    logic [15:0] cap_val;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    card_rst_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cclk_en(cclk_en), .ext_rst(ext_rst),
        .card_io(card_io), .crst(crst), .done(done), .cap_val(cap_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cclk_en = 1'b1;
            @(negedge clk);
            cclk_en = 1'b0;
            if (i % 3 == 1) @(negedge clk);
        end
    endtask

    task automatic start(input int n);
        wr(2'd2, 8'h00);
        wr(2'd0, n[7:0]);
        wr(2'd1, n[15:8]);
        wr(2'd2, 8'h02);
        wr(2'd2, 8'h0A);
        idle(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 crst after reset", crst, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 cap after reset", cap_val, 0);

        wr(2'd2, 8'h01);
        chk("R2 sw level high", crst, 1);
        wr(2'd2, 8'h00);
        chk("R2 sw level low", crst, 0);

        wr(2'd2, 8'h05);
        idle(1);
        chk("R3 pin mode overrides sw bit", crst, 0);
        ext_rst = 1'b1;
        idle(1);
        chk("R3 rise follows pin", crst, 1);
        ext_rst = 1'b0;
        idle(1);
        chk("R3 fall follows pin", crst, 0);
        wr(2'd2, 8'h07);
        ext_rst = 1'b1;
        idle(1);
        chk("R3 pin mode over timed mode", crst, 1);
        ext_rst = 1'b0;
        wr(2'd2, 8'h00);

        // default target of 400
        wr(2'd2, 8'h02);
        wr(2'd2, 8'h0A);
        idle(1);
        cclk_en = 1'b1;
        idle(200);
        cclk_en = 1'b0;
        card_io = 1'b0; idle(2); card_io = 1'b1; idle(2);
        chk("R10 fall before release ignored", cap_val, 0);
        idle(50);
        chk("R5 stopped clock holds line", crst, 0);
        cclk_en = 1'b1;
        idle(199);
        cclk_en = 1'b0;
        chk("R1 low before tick 400", crst, 0);
        chk("R7 no done before release", done, 0);
        ticks(1);
        chk("R1 high at tick 400", crst, 1);
        chk("R7 done on release", done, 1);
        idle(1);
        chk("R7 done lasts one cycle", done, 0);

        // capture of elapsed ticks
        idle(2);
        ticks(7);
        card_io = 1'b0; idle(1);
        chk("R10 first fall captures", cap_val, 7);
        card_io = 1'b1; idle(1);
        ticks(3);
        card_io = 1'b0; idle(1);
        chk("R10 second fall ignored", cap_val, 7);
        card_io = 1'b1;

        // R11 leave timed mode
        wr(2'd2, 8'h00);
        chk("R11 line low after clearing mode", crst, 0);
        wr(2'd2, 8'h02);
        idle(2);
        chk("R11 re-enable without start stays low", crst, 0);
        wr(2'd2, 8'h03);
        idle(1);
        chk("R11 sw bit ignored in timed mode", crst, 0);

        // sweep of targets
        for (int k = 0; k < 9; k++) begin
            int n;
            case (k)
                0: n = 0;   1: n = 1;   2: n = 2;
                3: n = 3;   4: n = 5;   5: n = 17;
                6: n = 255; 7: n = 256; default: n = 300;
            endcase
            start(n);
            chk("R4 low right after start", crst, 0);
            if (n == 0) begin
                idle(1);
                chk("R6 zero target releases", crst, 1);
            end else begin
                if (n > 1) ticks(n - 1);
                chk("R4 low before last tick", crst, 0);
                ticks(1);
                if (n == 1) chk("R6 one tick target releases", crst, 1);
                else        chk("R4 high after last tick", crst, 1);
            end
        end

        // R8 reload on low byte write
        start(10);
        ticks(5);
        wr(2'd0, 8'd3);
        idle(1);
        ticks(2);
        chk("R8 low before reloaded end", crst, 0);
        ticks(1);
        chk("R8 release after reloaded count", crst, 1);
        start(6);
        ticks(2);
        wr(2'd1, 8'h01);
        idle(1);
        ticks(3);
        chk("R8 high byte write keeps count", crst, 0);
        ticks(1);
        chk("R8 release at original target", crst, 1);

        // R9 warm reset
        start(20);
        ticks(4);
        wr(2'd2, 8'h12);
        idle(1);
        ticks(15);
        chk("R9 warm during cold ignored low", crst, 0);
        ticks(1);
        chk("R9 warm during cold ignored release", crst, 1);
        idle(2);
        ticks(4);
        card_io = 1'b0; idle(1); card_io = 1'b1;
        chk("R10 capture after cold", cap_val, 4);
        wr(2'd2, 8'h12);
        chk("R9 still high in write cycle", crst, 1);
        idle(1);
        chk("R9 warm drives line low", crst, 0);
        ticks(19);
        chk("R9 low before warm end", crst, 0);
        ticks(1);
        chk("R9 warm release", crst, 1);
        chk("R7 done on warm release", done, 1);
        idle(2);
        ticks(5);
        card_io = 1'b0; idle(1); card_io = 1'b1;
        chk("R10 warm release re-arms", cap_val, 5);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h02);
        wr(2'd2, 8'h12);
        idle(1);
        ticks(30);
        chk("R9 warm in idle ignored", crst, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule